// File: doc/BRIEF.md
# Programmable Slow Memory Clock Generator

This block derives a slow clock for a nonvolatile memory from a faster bus clock. It counts bus-clock cycles. A 6-bit divide field sets the length of one output period: the output period is the field value plus one, in bus cycles. The output is high for the first half of each period and low for the rest. When the period is odd, the extra cycle goes to the low phase.

Software writes the divide field, then polls a clock-okay flag before it raises the bus frequency. A written value is held as pending and only becomes active at the end of the current output period, so the memory never sees a shortened pulse. A field value of zero is not a legal divide and is treated as the default divide of 15. The register still reads back the zero that was written.

Top module: `slow_mem_clkgen`

## Requirements
- R1: With effective divide value E, every output period lasts E+1 bus cycles. The output is high for floor((E+1)/2) cycles, starting with the first cycle of the period, and low for the remaining cycles.
- R2: The extremes of the legal range work: value 1 gives 1 high and 1 low cycle, and value 63 gives 32 high and 32 low cycles.
- R3: A programmed value of 0 gives the same output as value 15. Reading back the register still returns 0.
- R4: A written value does not change the period in progress. The old period finishes at the old value, and the new value takes effect from the next period start.
- R5: A write captured on the last cycle of a period takes effect at the boundary that follows it. The next period already runs at the new value, and clock-okay stays 1.
- R6: A write whose effective value differs from the active value drives clock-okay to 0 in the following cycle. Clock-okay returns to 1 in the first cycle of the first period at the new value.
- R7: A write whose effective value equals the active value leaves clock-okay at 1. This includes writing 0 while 15 is active.
- R8: During and after reset, the register reads 15, clock-okay is 1 and the output clock is high.
- R9: The register readback shows the last written value from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| wr_en_i | input | 1 | Write strobe for the divide field |
| wr_div_i | input | 6 | Divide value to write |
| div_q_o | output | 6 | Readback of the programmed divide field |
| clk_ok_o | output | 1 | 1 when the programmed setting is the one in use |
| mem_clk_o | output | 1 | Divided clock for the memory |

## Verification
A register write and a period boundary can fall in the same bus cycle. These are the pending-value capture and the changeover of the active divide.

The bench provokes this case as follows. It first locks onto the rising edge of the output. It then counts forward to the last cycle of the period and presents a write exactly there.

It judges the result at the ports. Clock-okay must stay 1. The very next high phase and low phase must already have the lengths of the new value, with no period at the old value in between.

// File: rtl/smclk_pkg.sv
package smclk_pkg;
  localparam int unsigned DIV_W_DEF   = 6;
  localparam int unsigned DEF_DIV_DEF = 15;
endpackage

// File: rtl/smclk_rst_sync.sv
module smclk_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/smclk_cfg.sv
// Programmed field, active divide and clock-okay flag.
module smclk_cfg #(
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned DEF_DIV = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DIV_W-1:0] wr_val_i,
  input  logic             wrap_i,
  output logic [DIV_W-1:0] prog_o,
  output logic [DIV_W-1:0] act_o,
  output logic [DIV_W-1:0] act_nxt_o,
  output logic             ok_o
);
  localparam logic [DIV_W-1:0] DEF_V = DEF_DIV[DIV_W-1:0];

  logic [DIV_W-1:0] prog_q, prog_n, act_q, act_n, eff_n;
  logic             ok_q, ok_n;

  function automatic logic [DIV_W-1:0] eff_of(input logic [DIV_W-1:0] v);
    return (v == '0) ? DEF_V : v;
  endfunction

  always_comb begin
    prog_n = wr_en_i ? wr_val_i : prog_q;
    eff_n  = eff_of(prog_n);
    act_n  = wrap_i ? eff_n : act_q;
    ok_n   = (eff_n == act_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q <= DEF_V;
    end else if (wr_en_i) begin
      prog_q <= prog_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= DEF_V;
      ok_q  <= 1'b1;
    end else begin
      act_q <= act_n;
      ok_q  <= ok_n;
    end
  end

  assign prog_o    = prog_q;
  assign act_o     = act_q;
  assign act_nxt_o = act_n;
  assign ok_o      = ok_q;
endmodule

// File: rtl/smclk_div_core.sv
// Period counter with a registered clock output.
module smclk_div_core #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] act_i,
  input  logic [DIV_W-1:0] act_nxt_i,
  output logic             wrap_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic             clk_o
);
  localparam int unsigned EXT_W = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [EXT_W-1:0] hi_len_n;
  logic             out_q, out_n;
  logic             wrap;

  always_comb begin
    wrap     = (cnt_q == act_i);
    cnt_n    = wrap ? '0 : cnt_q + 1'b1;
    hi_len_n = ({1'b0, act_nxt_i} + 1'b1) >> 1;
    out_n    = ({1'b0, cnt_n} < hi_len_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      out_q <= out_n;
    end
  end

  assign wrap_o = wrap;
  assign cnt_o  = cnt_q;
  assign clk_o  = out_q;
endmodule

// File: rtl/slow_mem_clkgen.sv
module slow_mem_clkgen #(
  parameter int unsigned DIV_W   = smclk_pkg::DIV_W_DEF,
  parameter int unsigned DEF_DIV = smclk_pkg::DEF_DIV_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DIV_W-1:0] wr_div_i,
  output logic [DIV_W-1:0] div_q_o,
  output logic             clk_ok_o,
  output logic             mem_clk_o
);
  logic             rst_sync_n;
  logic             wrap;
  logic [DIV_W-1:0] act_q, act_nxt, cnt_q;

  smclk_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  smclk_cfg #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_val_i  (wr_div_i),
    .wrap_i    (wrap),
    .prog_o    (div_q_o),
    .act_o     (act_q),
    .act_nxt_o (act_nxt),
    .ok_o      (clk_ok_o)
  );

  smclk_div_core #(.DIV_W(DIV_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .act_i     (act_q),
    .act_nxt_i (act_nxt),
    .wrap_o    (wrap),
    .cnt_o     (cnt_q),
    .clk_o     (mem_clk_o)
  );
endmodule

// File: rtl/smclk_chk.sv
module smclk_chk #(
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned DEF_DIV = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [DIV_W-1:0] wr_div_i,
  input logic [DIV_W-1:0] div_q_o,
  input logic             clk_ok_o,
  input logic             mem_clk_o,
  input logic [DIV_W-1:0] act_q,
  input logic [DIV_W-1:0] cnt_q
);
  logic [DIV_W-1:0] wr_eff;
  assign wr_eff = (wr_div_i == '0) ? DEF_DIV[DIV_W-1:0] : wr_div_i;

  // R1: the counter never runs past the active period
  a_r1_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_q);

  // R1: every period opens with the high phase
  a_r1_high_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> mem_clk_o);

  // R3: zero never becomes the active divide
  a_r3_no_zero_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q != '0);

  // R4: the active divide changes only after a period's last cycle
  a_r4_change_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> ($past(cnt_q) == $past(act_q)));

  // R6: okay drops after a changing write taken mid-period
  a_r6_ok_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_eff != act_q) && (cnt_q != act_q)) |=> !clk_ok_o);

  // R6: okay comes back only at a period start
  a_r6_ok_rises_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_ok_o) |-> (cnt_q == '0));

  // R9: readback follows the write one cycle later
  a_r9_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (div_q_o == $past(wr_div_i)));
endmodule

bind slow_mem_clkgen smclk_chk #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_sync_n),
  .wr_en_i   (wr_en_i),
  .wr_div_i  (wr_div_i),
  .div_q_o   (div_q_o),
  .clk_ok_o  (clk_ok_o),
  .mem_clk_o (mem_clk_o),
  .act_q     (act_q),
  .cnt_q     (cnt_q)
);

// File: tb/tb_slow_mem_clkgen.sv
`timescale 1ns/1ps
module tb_slow_mem_clkgen;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_en_i;
  logic [5:0] wr_div_i;
  logic [5:0] div_q_o;
  logic       clk_ok_o;
  logic       mem_clk_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  slow_mem_clkgen dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_div_i  (wr_div_i),
    .div_q_o   (div_q_o),
    .clk_ok_o  (clk_ok_o),
    .mem_clk_o (mem_clk_o)
  );

  // value, expected high cycles, expected low cycles
  localparam int VEC_N = 9;
  localparam int VEC [VEC_N][3] = '{
    '{7, 4, 4}, '{1, 1, 1}, '{63, 32, 32}, '{0, 8, 8}, '{10, 5, 6},
    '{2, 1, 2}, '{62, 31, 32}, '{15, 8, 8}, '{3, 2, 2}};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // called just after a falling edge; returns at the falling edge after capture
  task automatic do_write(input int v);
    wr_en_i  = 1'b1;
    wr_div_i = 6'(v);
    @(negedge clk_i);
    wr_en_i  = 1'b0;
  endtask

  task automatic wait_ok();
    for (int i = 0; i < 200 && !clk_ok_o; i++) @(negedge clk_i);
  endtask

  // returns at a falling edge that lies in the first cycle of a period
  task automatic sync_rise();
    for (int i = 0; i < 200 && mem_clk_o; i++) @(negedge clk_i);
    for (int i = 0; i < 200 && !mem_clk_o; i++) @(negedge clk_i);
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (mem_clk_o == lvl && n < 200) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int hi, lo, n;
    rst_ni   = 1'b0;
    wr_en_i  = 1'b0;
    wr_div_i = '0;
    repeat (3) @(negedge clk_i);
    // R8: reset state
    chk("R8 div_q in reset", int'(div_q_o), 15);
    chk("R8 clk_ok in reset", int'(clk_ok_o), 1);
    chk("R8 mem_clk in reset", int'(mem_clk_o), 1);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R8 clk_ok after reset", int'(clk_ok_o), 1);

    // R7 / R3 / R9: writing 0 while 15 is active
    do_write(0);
    chk("R7 ok stays on zero write", int'(clk_ok_o), 1);
    chk("R3 readback of zero", int'(div_q_o), 0);
    chk("R9 readback next cycle", int'(div_q_o), 0);

    // R1 / R2 / R3: table of values
    for (int k = 0; k < VEC_N; k++) begin
      do_write(VEC[k][0]);
      wait_ok();
      sync_rise();
      count_level(1'b1, hi);
      count_level(1'b0, lo);
      chk($sformatf("R1 high value %0d", VEC[k][0]), hi, VEC[k][1]);
      chk($sformatf("R1 low value %0d", VEC[k][0]), lo, VEC[k][2]);
    end

    // R5: write captured on the last cycle of a period (active value 3)
    sync_rise();
    repeat (3) @(negedge clk_i);
    do_write(5);
    chk("R5 ok stays on boundary write", int'(clk_ok_o), 1);
    count_level(1'b1, hi);
    count_level(1'b0, lo);
    chk("R5 high at new value", hi, 3);
    chk("R5 low at new value", lo, 3);

    // R6 / R4: mid-period change from 7 to 40
    do_write(7);
    wait_ok();
    sync_rise();
    do_write(40);
    chk("R6 ok drops after write", int'(clk_ok_o), 0);
    n = 0;
    hi = 0;
    while (!clk_ok_o && n < 200) begin
      n++;
      if (mem_clk_o) hi++;
      @(negedge clk_i);
    end
    chk("R6 ok low cycles", n, 7);
    chk("R4 old period high remainder", hi, 3);
    chk("R6 new period starts high", int'(mem_clk_o), 1);
    count_level(1'b1, hi);
    chk("R4 first new high phase", hi, 20);

    // R7: rewriting the active value
    do_write(40);
    chk("R7 ok stays on same value", int'(clk_ok_o), 1);
    chk("R9 readback 40", int'(div_q_o), 40);

    finish_run();
  end
endmodule